// File: doc/BRIEF.md
# Program Status Register Bank

This block keeps the processor's live status word together with five saved status words, one for each exception mode (fast interrupt, interrupt, supervisor, abort, undefined). When the core takes an exception, the block stores the live word into the saved slot of the mode being entered. In the same cycle it switches the mode field and sets the interrupt masks. When the core returns from an exception, the live word is reloaded from the saved slot that belongs to the current mode.

Software may rewrite the live word through a strobe that carries data and a two-bit field mask. The ALU may overwrite the four arithmetic flags. Only privileged modes may change the control byte. The block reports the live word, the saved word visible in the current mode, a decoded mode index and a privilege indication. It also raises a one-cycle error pulse when a return is requested from a mode that has no saved word.

Top module: `psr_bank`

## Requirements
- R1: After a cycle with rst_n low, the live word reads 0x000000D3 (supervisor mode, I and F set, all flags and T clear), the visible saved word reads zero, mode_idx reads 3, priv is 1 and ret_err is 0.
- R2: Only bits 31..27 (N, Z, C, V, Q), bit 7 (I), bit 6 (F), bit 5 (T) and bits 4..0 (mode) are stored. Every other bit of both outputs reads zero whatever is written.
- R3: An entry request with a target of fiq (10001), irq (10010), svc (10011), abt (10111) or und (11011) has the following effect at the next edge. The target's saved slot receives the prior live word. The mode field becomes the target, I is set, T is cleared and the flags are kept. F is set for a fiq target and is otherwise unchanged.
- R4: An entry request whose target is user (10000), system (11111) or any other code is treated as absent.
- R5: A return request in any of the five exception modes reloads the whole live word from that mode's saved slot.
- R6: A return request in user or system mode changes nothing, and ret_err is high for exactly the one following cycle.
- R7: The spsr output shows the saved slot of the current mode, and reads zero in user and system mode.
- R8: A software write copies data bits 31..27 when sw_fmask bit 1 is set. When sw_fmask bit 0 is set in a privileged mode, it copies data bits 7..0. A mask of 00 changes nothing.
- R9: In user mode a software write leaves bits 7..0 unchanged, while its flag field still applies.
- R10: A privileged control-byte write whose bits 4..0 are not one of the seven legal mode codes leaves bits 7..0 unchanged.
- R11: A flag update writes alu_nzcv[3:0] to bits 31..28 and leaves Q and the control byte unchanged.
- R12: When several requests coincide, only one is applied, in this order: a valid entry, then a return, then a software write, then a flag update.
- R13: mode_idx encodes user=0, fiq=1, irq=2, svc=3, abt=4, und=5, sys=6. priv is low only in user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Mode code of the exception being entered |
| ret_req | input | 1 | Exception return strobe |
| sw_we | input | 1 | Software write strobe |
| sw_data | input | 32 | Software write data |
| sw_fmask | input | 2 | Field select: bit 1 flags, bit 0 control byte |
| alu_we | input | 1 | Flag update strobe |
| alu_nzcv | input | 4 | New N, Z, C, V values (bit 3 = N) |
| cpsr | output | 32 | Live status word |
| spsr | output | 32 | Saved word of the current mode |
| mode_idx | output | 3 | Decoded mode index |
| priv | output | 1 | High in any mode other than user |
| ret_err | output | 1 | One-cycle pulse after an ignored return |

## Verification
The hardest situation to reach from the ports is a return that must restore a word which was itself saved inside another exception. This requires nested entries whose saved slots hold distinct, non-reset values. The stimulus reaches it by several steps. It first leaves supervisor mode, drops into user mode and sets distinctive flags. It then enters irq, enters fiq from irq and enters undefined from fiq. Finally it unwinds step by step and checks each restored word and the saved word that becomes visible. The entry into undefined is issued with every other strobe active, and the following return is issued with a write and a flag update. This exercises the priority order at the points where a wrong winner would corrupt the unwind.

// File: rtl/psr_pkg.sv
// Package: shared encodings, the compact status record and packing helpers
// for the status register bank. Assumes a 32-bit architectural word.
package psr_pkg;
    localparam int DATA_W = 32;
    localparam int MODE_W = 5;
    localparam int N_BANK = 5;

    // Architectural bit positions
    localparam int POS_N = 31;
    localparam int POS_Z = 30;
    localparam int POS_C = 29;
    localparam int POS_V = 28;
    localparam int POS_Q = 27;
    localparam int POS_I = 7;
    localparam int POS_F = 6;
    localparam int POS_T = 5;

    // Mode codes
    localparam logic [MODE_W-1:0] M_USR = 5'b10000;
    localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M_UND = 5'b11011;
    localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

    // Saved-slot index of each exception mode
    localparam int BK_FIQ = 0;
    localparam int BK_IRQ = 1;
    localparam int BK_SVC = 2;
    localparam int BK_ABT = 3;
    localparam int BK_UND = 4;

    typedef enum logic [2:0] {
        MI_USR = 3'd0,
        MI_FIQ = 3'd1,
        MI_IRQ = 3'd2,
        MI_SVC = 3'd3,
        MI_ABT = 3'd4,
        MI_UND = 3'd5,
        MI_SYS = 3'd6,
        MI_BAD = 3'd7
    } mode_idx_e;

    // Only the implemented bits are stored
    typedef struct packed {
        logic              n;
        logic              z;
        logic              c;
        logic              v;
        logic              q;
        logic              i;
        logic              f;
        logic              t;
        logic [MODE_W-1:0] m;
    } psr_t;

    localparam int PSR_W = $bits(psr_t);

    localparam psr_t PSR_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0, q: 1'b0,
                                   i: 1'b1, f: 1'b1, t: 1'b0, m: M_SVC};

    // Expand the compact record to the architectural word
    function automatic logic [DATA_W-1:0] psr_word(psr_t p);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[POS_N]     = p.n;
        w[POS_Z]     = p.z;
        w[POS_C]     = p.c;
        w[POS_V]     = p.v;
        w[POS_Q]     = p.q;
        w[POS_I]     = p.i;
        w[POS_F]     = p.f;
        w[POS_T]     = p.t;
        w[MODE_W-1:0] = p.m;
        return w;
    endfunction

    // Mask of the stored bits in the architectural word
    localparam logic [DATA_W-1:0] USED_MASK = 32'hF800_00FF;
endpackage

// File: rtl/psr_mode_dec.sv
// Mode decoder: turns a 5-bit mode code into an index, a one-hot saved-slot
// select, and legal / banked / privileged indications.
// Assumes: any code outside the seven legal codes is reported as MI_BAD.
module psr_mode_dec
    import psr_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_idx_e         idx,
    output logic [N_BANK-1:0] bank_oh,
    output logic              legal,
    output logic              banked,
    output logic              priv
);
    // Decode the code into an index and a saved-slot select
    always_comb begin
        idx     = MI_BAD;
        bank_oh = '0;
        case (mode)
            M_USR: idx = MI_USR;
            M_SYS: idx = MI_SYS;
            M_FIQ: begin idx = MI_FIQ; bank_oh[BK_FIQ] = 1'b1; end
            M_IRQ: begin idx = MI_IRQ; bank_oh[BK_IRQ] = 1'b1; end
            M_SVC: begin idx = MI_SVC; bank_oh[BK_SVC] = 1'b1; end
            M_ABT: begin idx = MI_ABT; bank_oh[BK_ABT] = 1'b1; end
            M_UND: begin idx = MI_UND; bank_oh[BK_UND] = 1'b1; end
            default: idx = MI_BAD;
        endcase
    end

    // Summary flags derived from the decoded index
    always_comb begin
        legal  = (idx != MI_BAD);
        banked = |bank_oh;
        priv   = legal && (idx != MI_USR);
    end
endmodule

// File: rtl/psr_save_bank.sv
// Saved status slots: one register per exception mode, written by a one-hot
// select and read through a one-hot select (zero when no slot is selected).
// Assumes: at most one write select and one read select are high at a time.
module psr_save_bank #(
    parameter int N_SLOT = 5,
    parameter int W      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SLOT-1:0] wr_oh,
    input  logic [W-1:0]      wr_val,
    input  logic [N_SLOT-1:0] rd_oh,
    output logic [W-1:0]      rd_val
);
    logic [W-1:0] slot_q [N_SLOT];

    // Clear every slot at reset, load the selected slot on a write
    always_ff @(posedge clk) begin
        for (int j = 0; j < N_SLOT; j++) begin
            if (!rst_n)
                slot_q[j] <= '0;
            else if (wr_oh[j])
                slot_q[j] <= wr_val;
        end
    end

    // OR-combine the selected slot onto the read port
    always_comb begin
        rd_val = '0;
        for (int j = 0; j < N_SLOT; j++)
            if (rd_oh[j]) rd_val = rd_val | slot_q[j];
    end

    // R3
    wr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_oh));
    // R7
    rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_oh));
endmodule

// File: rtl/psr_next.sv
// Next-state selector for the live status record. It applies exactly one of
// entry, return, software write or flag update, in that priority order.
// Assumes: decoder outputs for the current, target and written modes are valid.
module psr_next
    import psr_pkg::*;
(
    input  psr_t              cur,
    input  logic              cur_banked,
    input  logic              cur_priv,
    input  psr_t              saved,
    input  logic              exc_req,
    input  logic [MODE_W-1:0] exc_mode,
    input  logic              tgt_banked,
    input  logic              ret_req,
    input  logic              sw_we,
    input  logic [DATA_W-1:0] sw_data,
    input  logic [1:0]        sw_fmask,
    input  logic              wr_legal,
    input  logic              alu_we,
    input  logic [3:0]        alu_nzcv,
    output psr_t              nxt,
    output logic              entry_go,
    output logic              ret_bad
);
    // An entry request only counts when its target owns a saved slot
    always_comb entry_go = exc_req && tgt_banked;

    // Pick the single winning operation and form the next record
    always_comb begin
        nxt     = cur;
        ret_bad = 1'b0;
        if (entry_go) begin
            nxt.m = exc_mode;
            nxt.i = 1'b1;
            nxt.t = 1'b0;
            if (exc_mode == M_FIQ) nxt.f = 1'b1;
        end else if (ret_req) begin
            if (cur_banked) nxt = saved;
            else            ret_bad = 1'b1;
        end else if (sw_we) begin
            if (sw_fmask[1]) begin
                nxt.n = sw_data[POS_N];
                nxt.z = sw_data[POS_Z];
                nxt.c = sw_data[POS_C];
                nxt.v = sw_data[POS_V];
                nxt.q = sw_data[POS_Q];
            end
            if (sw_fmask[0] && cur_priv && wr_legal) begin
                nxt.i = sw_data[POS_I];
                nxt.f = sw_data[POS_F];
                nxt.t = sw_data[POS_T];
                nxt.m = sw_data[MODE_W-1:0];
            end
        end else if (alu_we) begin
            {nxt.n, nxt.z, nxt.c, nxt.v} = alu_nzcv;
        end
    end
endmodule

// File: rtl/psr_bank.sv
// Status register bank top: live status record, five saved slots, mode
// decoding and the return error pulse.
// Assumes: synchronous active-low reset held for at least one clock edge.
module psr_bank
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [4:0]        exc_mode,
    input  logic              ret_req,
    input  logic              sw_we,
    input  logic [31:0]       sw_data,
    input  logic [1:0]        sw_fmask,
    input  logic              alu_we,
    input  logic [3:0]        alu_nzcv,
    output logic [31:0]       cpsr,
    output logic [31:0]       spsr,
    output logic [2:0]        mode_idx,
    output logic              priv,
    output logic              ret_err
);
    psr_t              live_q;
    psr_t              live_d;
    psr_t              saved_rd;
    logic [PSR_W-1:0]  saved_bits;
    logic [N_BANK-1:0] save_oh;
    logic              entry_go;
    logic              ret_bad;

    mode_idx_e         cur_idx,    tgt_idx,    wr_idx;
    logic [N_BANK-1:0] cur_oh,     tgt_oh,     wr_oh;
    logic              cur_legal,  tgt_legal,  wr_legal;
    logic              cur_banked, tgt_banked, wr_banked;
    logic              cur_priv,   tgt_priv,   wr_priv;

    psr_mode_dec u_cur_dec (
        .mode(live_q.m), .idx(cur_idx), .bank_oh(cur_oh),
        .legal(cur_legal), .banked(cur_banked), .priv(cur_priv)
    );
    psr_mode_dec u_tgt_dec (
        .mode(exc_mode), .idx(tgt_idx), .bank_oh(tgt_oh),
        .legal(tgt_legal), .banked(tgt_banked), .priv(tgt_priv)
    );
    psr_mode_dec u_wr_dec (
        .mode(sw_data[MODE_W-1:0]), .idx(wr_idx), .bank_oh(wr_oh),
        .legal(wr_legal), .banked(wr_banked), .priv(wr_priv)
    );

    psr_next u_next (
        .cur(live_q), .cur_banked(cur_banked), .cur_priv(cur_priv),
        .saved(saved_rd), .exc_req(exc_req), .exc_mode(exc_mode),
        .tgt_banked(tgt_banked), .ret_req(ret_req), .sw_we(sw_we),
        .sw_data(sw_data), .sw_fmask(sw_fmask), .wr_legal(wr_legal),
        .alu_we(alu_we), .alu_nzcv(alu_nzcv), .nxt(live_d),
        .entry_go(entry_go), .ret_bad(ret_bad)
    );

    // Write the entry target's slot only on an accepted entry
    always_comb save_oh = entry_go ? tgt_oh : '0;

    psr_save_bank #(.N_SLOT(N_BANK), .W(PSR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_oh(save_oh), .wr_val(live_q),
        .rd_oh(cur_oh), .rd_val(saved_bits)
    );

    // Reinterpret the raw slot bits as a status record
    always_comb saved_rd = psr_t'(saved_bits);

    // Live status record and error pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q  <= PSR_RESET;
            ret_err <= 1'b0;
        end else begin
            live_q  <= live_d;
            ret_err <= ret_bad;
        end
    end

    // Drive the architectural views
    always_comb begin
        cpsr     = psr_word(live_q);
        spsr     = psr_word(saved_rd);
        mode_idx = cur_idx;
        priv     = cur_priv;
    end

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpsr & ~USED_MASK) == '0) && ((spsr & ~USED_MASK) == '0));
    // R3 R12
    entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && tgt_banked) |=> (cpsr[4:0] == $past(exc_mode)) && cpsr[POS_I]
            && !cpsr[POS_T] && (cpsr[31:27] == $past(cpsr[31:27])));
    // R3
    entry_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && tgt_banked) |=> (spsr == $past(cpsr)));
    // R3
    entry_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && exc_mode == M_FIQ) |=> cpsr[POS_F]);
    // R4
    entry_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && !tgt_banked && !ret_req && !sw_we && !alu_we) |=> $stable(cpsr));
    // R5
    return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !entry_go && cur_banked) |=> (cpsr == $past(spsr)));
    // R6
    ret_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !entry_go && !cur_banked) |=> (ret_err && $stable(cpsr)));
    // R6
    ret_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_err) |-> $past(ret_req));
    // R9
    user_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv && sw_we && !entry_go && !ret_req) |=> (cpsr[7:0] == $past(cpsr[7:0])));
    // R11
    alu_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_we && !exc_req && !ret_req && !sw_we) |=>
            (cpsr[31:28] == $past(alu_nzcv)) && (cpsr[27:0] == $past(cpsr[27:0])));
endmodule

// File: tb/psr_bank_tb_top.sv
// Scoreboard bench for psr_bank: the driver applies one operation per cycle
// and queues the expected outputs; the monitor compares after each edge.
module psr_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_mode = '0;
    logic        ret_req = 1'b0;
    logic        sw_we = 1'b0;
    logic [31:0] sw_data = '0;
    logic [1:0]  sw_fmask = '0;
    logic        alu_we = 1'b0;
    logic [3:0]  alu_nzcv = '0;
    logic [31:0] cpsr, spsr;
    logic [2:0]  mode_idx;
    logic        priv, ret_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] cpsr;
        logic [31:0] spsr;
        logic [2:0]  mi;
        logic        priv;
        logic        err;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur_e;

    // Reference state built from the requirements
    logic [31:0] m_cpsr;
    logic [31:0] m_spsr [5];

    always #2.5 clk = ~clk;

    psr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_mode(exc_mode),
        .ret_req(ret_req), .sw_we(sw_we), .sw_data(sw_data), .sw_fmask(sw_fmask),
        .alu_we(alu_we), .alu_nzcv(alu_nzcv), .cpsr(cpsr), .spsr(spsr),
        .mode_idx(mode_idx), .priv(priv), .ret_err(ret_err)
    );

    // Saved-slot number of a mode code, -1 when it has none (R3, R7)
    function automatic int slot_of(logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    // Mode index per R13
    function automatic logic [2:0] idx_of(logic [4:0] m);
        case (m)
            5'b10000: return 3'd0;
            5'b10001: return 3'd1;
            5'b10010: return 3'd2;
            5'b10011: return 3'd3;
            5'b10111: return 3'd4;
            5'b11011: return 3'd5;
            5'b11111: return 3'd6;
            default:  return 3'd7;
        endcase
    endfunction

    function automatic bit legal_mode(logic [4:0] m);
        return idx_of(m) != 3'd7;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and queue what the outputs must be after it
    task automatic step(input logic e, input logic [4:0] em, input logic r,
                        input logic w, input logic [31:0] d, input logic [1:0] fm,
                        input logic a, input logic [3:0] nz, input string tag);
        exp_t x;
        logic [31:0] nx;
        int b;
        exc_req = e; exc_mode = em; ret_req = r;
        sw_we = w; sw_data = d; sw_fmask = fm;
        alu_we = a; alu_nzcv = nz;
        nx = m_cpsr;
        x.err = 1'b0;
        if (e && slot_of(em) >= 0) begin
            m_spsr[slot_of(em)] = m_cpsr;
            nx[4:0] = em;
            nx[7]   = 1'b1;
            nx[5]   = 1'b0;
            if (em == 5'b10001) nx[6] = 1'b1;
        end else if (r) begin
            b = slot_of(m_cpsr[4:0]);
            if (b >= 0) nx = m_spsr[b];
            else        x.err = 1'b1;
        end else if (w) begin
            if (fm[1]) nx[31:27] = d[31:27];
            if (fm[0] && m_cpsr[4:0] != 5'b10000 && legal_mode(d[4:0])) nx[7:0] = d[7:0];
        end else if (a) begin
            nx[31:28] = nz;
        end
        m_cpsr = nx;
        b = slot_of(m_cpsr[4:0]);
        x.cpsr = m_cpsr;
        x.spsr = (b >= 0) ? m_spsr[b] : 32'h0;
        x.mi   = idx_of(m_cpsr[4:0]);
        x.priv = (m_cpsr[4:0] != 5'b10000);
        x.tag  = tag;
        exp_q.push_back(x);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 5'b0, 1'b0, 1'b0, 32'h0, 2'b00, 1'b0, 4'h0, tag);
    endtask

    // Monitor: compare after each edge, clear of both edges
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            cur_e = exp_q.pop_front();
            check(cur_e.tag, cpsr, cur_e.cpsr, "cpsr");
            check(cur_e.tag, spsr, cur_e.spsr, "spsr");
            check(cur_e.tag, {29'd0, mode_idx}, {29'd0, cur_e.mi}, "mode_idx");
            check(cur_e.tag, {31'd0, priv}, {31'd0, cur_e.priv}, "priv");
            check(cur_e.tag, {31'd0, ret_err}, {31'd0, cur_e.err}, "ret_err");
        end
    end

    // Watchdog: a hung run is a failed check and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: cycles actual 20000 expected fewer");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        m_cpsr = 32'h0000_00D3;
        for (int k = 0; k < 5; k++) m_spsr[k] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", cpsr, 32'h0000_00D3, "cpsr");
        check("R1", spsr, 32'h0, "spsr");
        check("R1", {29'd0, mode_idx}, 32'd3, "mode_idx");
        check("R1", {31'd0, priv}, 32'd1, "priv");
        check("R1", {31'd0, ret_err}, 32'd0, "ret_err");

        step(0, 0, 0, 1, 32'hFFFF_FFFF, 2'b11, 0, 0, "R2 R8 all-ones write");
        step(0, 0, 1, 0, 0, 0, 0, 0, "R6 return in system");
        idle("R6 pulse ends");
        step(0, 0, 0, 1, 32'h0000_0010, 2'b01, 0, 0, "R8 R13 enter user");
        step(0, 0, 0, 1, 32'h0000_00D3, 2'b11, 0, 0, "R9 user control write");
        step(0, 0, 0, 0, 0, 0, 1, 4'hA, "R11 flag update");
        step(0, 0, 1, 0, 0, 0, 0, 0, "R6 return in user");
        step(1, 5'b10010, 0, 0, 0, 0, 0, 0, "R3 R7 entry irq");
        step(1, 5'b10001, 0, 0, 0, 0, 0, 0, "R3 entry fiq");
        step(1, 5'b10000, 0, 0, 0, 0, 0, 0, "R4 user target");
        step(1, 5'b11111, 0, 0, 0, 0, 0, 0, "R4 system target");
        step(1, 5'b10101, 0, 0, 0, 0, 0, 0, "R4 unknown target");
        step(1, 5'b11011, 1, 1, 32'h0, 2'b11, 1, 4'h5, "R12 entry wins");
        step(0, 0, 1, 1, 32'h0, 2'b11, 1, 4'h5, "R5 R12 return wins");
        step(0, 0, 0, 1, 32'h5000_0015, 2'b11, 1, 4'hF, "R10 R12 write wins");
        step(0, 0, 1, 0, 0, 0, 0, 0, "R5 return to irq");
        step(0, 0, 0, 1, 32'h0000_0013, 2'b01, 0, 0, "R8 R13 to svc");
        step(0, 0, 0, 1, 32'h0800_0000, 2'b10, 0, 0, "R8 Q flag write");
        step(0, 0, 0, 0, 0, 0, 1, 4'hF, "R11 Q kept");
        step(1, 5'b10111, 0, 0, 0, 0, 0, 0, "R3 entry abort");
        step(0, 0, 0, 1, 32'hFFFF_FFFF, 2'b00, 0, 0, "R8 empty mask");
        step(0, 0, 1, 0, 0, 0, 0, 0, "R5 abort return");
        step(1, 5'b11011, 0, 0, 0, 0, 0, 0, "R3 entry und");
        step(1, 5'b11011, 0, 0, 0, 0, 0, 0, "R3 re-entry und");
        step(0, 0, 1, 0, 0, 0, 0, 0, "R5 und return");
        step(0, 0, 0, 1, 32'h0000_001F, 2'b01, 0, 0, "R13 to system");
        idle("R7 system hold");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule